// File: doc/BRIEF.md
# Five-Level Multicarrier PWM Gate Generator

This block drives the eight switches of a single-phase inverter made of two full-bridge cells in series, each cell on its own DC source. The sum of the two cell voltages can take five values, from minus twice the cell voltage up to plus twice that voltage. A signed modulating sample, which is the reference plus a correction from an external regulator, is compared against four triangular carriers. The carriers are built on chip from a clock-enable tick and stacked over the signed range. The number of carriers that the sample exceeds selects the output level. A fixed table turns the level into switch states.

Each cell has two legs, and each leg has an upper and a lower switch. A programmable dead time keeps the two switches of a leg from conducting together. The modulating sample is taken only once per carrier period, at the trough, so that a change of the input in mid-period cannot add extra switching edges. The signed level index is also brought out so that it can be checked directly.

Top module: `mlpwm_top`

## Requirements
- R1: The triangle value t counts up by one on each tick_i from 0 to P, then back down to 0, and repeats. P is period_i. Carrier k (k = 0..3) equals (k-2)*P + t. level_o, a 3-bit two's-complement value, equals the number of carriers that the sampled modulating value exceeds strictly, minus 2. It is registered one clock after the comparison.
- R2: mod_i is captured only on a tick where t is 0, the trough. A change of mod_i at any other time has no effect on level_o until the next trough.
- R3: Gate bit 4c+0 is the cell-c leg A upper switch, 4c+1 the leg A lower, 4c+2 the leg B upper and 4c+3 the leg B lower. Cell 0 is positive when level > 0, negative when level < 0, and zero otherwise. Cell 1 is positive when level > 1, negative when level < -1, and zero otherwise. Positive turns on A upper and B lower (nibble 1001). Negative turns on A lower and B upper (nibble 0110). Zero turns on both upper switches (nibble 0101). Once the level has been stable longer than the dead time, gate_o matches this table.
- R4: The upper and lower switches of the same leg are never high in the same cycle.
- R5: After one switch of a leg turns off, its complement stays off for at least dead_i clock cycles before it turns on.
- R6: With en_i low, all gates are low and level_o is 0 from the next clock. The sampled value is cleared and the triangle restarts at 0, rising. The first tick after en_i returns high is therefore a trough.
- R7: While rst_ni is low, all gates are low and level_o is 0.
- R8: A period_i of 0 behaves as a period of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable; low forces the gates off and restarts the carriers |
| tick_i | input | 1 | Clock enable for the carrier step |
| mod_i | input | MOD_W | Signed modulating sample |
| period_i | input | CNT_W | Carrier peak value P, in ticks |
| dead_i | input | DT_W | Dead time in clock cycles |
| gate_o | output | 4*N_CELLS | Gate signals, four per cell |
| level_o | output | LVL_W | Signed commanded level |

## Verification
The bench builds the block with its default parameters: two cells, 12-bit modulation, a 10-bit period and a 4-bit dead time. It drives a period of 8 with a tick on every second clock and a dead time of 2. With these settings a trough falls every 32 cycles, so the sampling and restart behaviour can be seen within a short run. The modulating values are placed inside, between and exactly on the carrier bounds. For each value the bench records the lowest and highest level seen over a full carrier period. A period of 0 exposes the minimum-period clamp, and monitors check the switch table, the leg exclusion and the dead-time gap on every cycle.

// File: rtl/mlpwm_pkg.sv
package mlpwm_pkg;

  typedef enum logic [1:0] {
    CELL_ZERO = 2'd0,
    CELL_POS  = 2'd1,
    CELL_NEG  = 2'd2
  } cell_state_e;

  // {leg_b_upper, leg_a_upper}
  function automatic logic [1:0] leg_upper(cell_state_e s);
    case (s)
      CELL_POS: return 2'b01;
      CELL_NEG: return 2'b10;
      default:  return 2'b11;
    endcase
  endfunction

endpackage

// File: rtl/mlpwm_carrier.sv
module mlpwm_carrier #(
  parameter int CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] period_i,
  output logic [CNT_W-1:0] tri_o,
  output logic [CNT_W-1:0] peak_o,
  output logic             trough_o
);

  logic [CNT_W-1:0] tri_q;
  logic             down_q;
  logic [CNT_W:0]   tri_inc;

  assign peak_o  = (period_i == '0) ? CNT_W'(1) : period_i;
  assign tri_inc = {1'b0, tri_q} + {{CNT_W{1'b0}}, 1'b1};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tri_q  <= '0;
      down_q <= 1'b0;
    end else if (!en_i) begin
      tri_q  <= '0;
      down_q <= 1'b0;
    end else if (tick_i) begin
      if (!down_q) begin
        if (tri_inc >= {1'b0, peak_o}) begin
          tri_q  <= peak_o;
          down_q <= 1'b1;
        end else begin
          tri_q <= tri_inc[CNT_W-1:0];
        end
      end else begin
        if (tri_q <= CNT_W'(1)) begin
          tri_q  <= '0;
          down_q <= 1'b0;
        end else begin
          tri_q <= tri_q - CNT_W'(1);
        end
      end
    end
  end

  assign tri_o    = tri_q;
  assign trough_o = en_i & tick_i & (tri_q == '0);

endmodule

// File: rtl/mlpwm_level.sv
module mlpwm_level #(
  parameter int N_CELLS = 2,
  parameter int MOD_W   = 12,
  parameter int CNT_W   = 10,
  parameter int LVL_W   = 3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic                    trough_i,
  input  logic signed [MOD_W-1:0] mod_i,
  input  logic [CNT_W-1:0]        tri_i,
  input  logic [CNT_W-1:0]        peak_i,
  output logic signed [LVL_W-1:0] level_o
);

  localparam int N_CAR = 2 * N_CELLS;
  localparam int CAR_W = CNT_W + $clog2(N_CELLS + 1) + 1;
  localparam int W     = ((MOD_W > CAR_W) ? MOD_W : CAR_W) + 1;

  logic signed [MOD_W-1:0] mod_q;
  logic signed [LVL_W-1:0] lvl_q, lvl_d;
  logic signed [W-1:0]     mod_w, t_w, p_w;
  logic signed [W-1:0]     car [N_CAR];
  int                      hits;

  assign mod_w = W'(mod_q);
  assign t_w   = W'({1'b0, tri_i});
  assign p_w   = W'({1'b0, peak_i});

  for (genvar k = 0; k < N_CAR; k++) begin : g_car
    localparam logic signed [W-1:0] OFF = W'(k - N_CELLS);
    assign car[k] = t_w + OFF * p_w;
  end

  always_comb begin
    hits = 0;
    for (int k = 0; k < N_CAR; k++) begin
      if (mod_w > car[k]) hits = hits + 1;
    end
    lvl_d = LVL_W'(hits - N_CELLS);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mod_q <= '0;
      lvl_q <= '0;
    end else if (!en_i) begin
      mod_q <= '0;
      lvl_q <= '0;
    end else begin
      if (trough_i) mod_q <= mod_i;
      lvl_q <= lvl_d;
    end
  end

  assign level_o = lvl_q;

endmodule

// File: rtl/mlpwm_cell_map.sv
module mlpwm_cell_map
  import mlpwm_pkg::*;
#(
  parameter int N_CELLS = 2,
  parameter int LVL_W   = 3
) (
  input  logic signed [LVL_W-1:0] level_i,
  output logic [2*N_CELLS-1:0]    leg_up_o
);

  for (genvar c = 0; c < N_CELLS; c++) begin : g_cell
    localparam int C = c;
    cell_state_e st;

    always_comb begin
      if (int'(level_i) > C)       st = CELL_POS;
      else if (int'(level_i) < -C) st = CELL_NEG;
      else                         st = CELL_ZERO;
    end

    assign leg_up_o[2*c +: 2] = leg_upper(st);
  end

endmodule

// File: rtl/mlpwm_leg_dt.sv
module mlpwm_leg_dt #(
  parameter int DT_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            up_req_i,
  input  logic [DT_W-1:0] dead_i,
  output logic            hi_o,
  output logic            lo_o
);

  logic            armed_q;
  logic            side_q;
  logic [DT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      side_q  <= 1'b0;
      cnt_q   <= '0;
    end else if (!en_i) begin
      armed_q <= 1'b0;
      side_q  <= 1'b0;
      cnt_q   <= '0;
    end else if (!armed_q || (up_req_i != side_q)) begin
      // commit new side, hold both off for the dead time
      armed_q <= 1'b1;
      side_q  <= up_req_i;
      cnt_q   <= dead_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - DT_W'(1);
    end
  end

  assign hi_o = armed_q &  side_q & (cnt_q == '0);
  assign lo_o = armed_q & ~side_q & (cnt_q == '0);

endmodule

// File: rtl/mlpwm_top.sv
module mlpwm_top #(
  parameter int N_CELLS = 2,
  parameter int MOD_W   = 12,
  parameter int CNT_W   = 10,
  parameter int DT_W    = 4,
  parameter int LVL_W   = $clog2(N_CELLS + 1) + 1,
  parameter int N_GATES = 4 * N_CELLS
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic                    tick_i,
  input  logic signed [MOD_W-1:0] mod_i,
  input  logic [CNT_W-1:0]        period_i,
  input  logic [DT_W-1:0]         dead_i,
  output logic [N_GATES-1:0]      gate_o,
  output logic signed [LVL_W-1:0] level_o
);

  localparam int N_LEGS = 2 * N_CELLS;

  logic [CNT_W-1:0]  tri_w, peak_w;
  logic              trough_w;
  logic [N_LEGS-1:0] leg_up_w;

  mlpwm_carrier #(.CNT_W(CNT_W)) u_carrier (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .tick_i   (tick_i),
    .period_i (period_i),
    .tri_o    (tri_w),
    .peak_o   (peak_w),
    .trough_o (trough_w)
  );

  mlpwm_level #(
    .N_CELLS (N_CELLS),
    .MOD_W   (MOD_W),
    .CNT_W   (CNT_W),
    .LVL_W   (LVL_W)
  ) u_level (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .trough_i (trough_w),
    .mod_i    (mod_i),
    .tri_i    (tri_w),
    .peak_i   (peak_w),
    .level_o  (level_o)
  );

  mlpwm_cell_map #(
    .N_CELLS (N_CELLS),
    .LVL_W   (LVL_W)
  ) u_map (
    .level_i  (level_o),
    .leg_up_o (leg_up_w)
  );

  for (genvar j = 0; j < N_LEGS; j++) begin : g_leg
    mlpwm_leg_dt #(.DT_W(DT_W)) u_leg (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .en_i     (en_i),
      .up_req_i (leg_up_w[j]),
      .dead_i   (dead_i),
      .hi_o     (gate_o[2*j]),
      .lo_o     (gate_o[2*j+1])
    );
  end

endmodule

// File: rtl/mlpwm_chk.sv
module mlpwm_chk #(
  parameter int N_CELLS = 2,
  parameter int DT_W    = 4,
  parameter int LVL_W   = 3
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    en_i,
  input logic [DT_W-1:0]         dead_i,
  input logic [4*N_CELLS-1:0]    gate_o,
  input logic signed [LVL_W-1:0] level_o
);

  a_r1_level_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(level_o) <= N_CELLS) && (int'(level_o) >= -N_CELLS));

  a_r6_gates_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (gate_o == '0));

  a_r6_level_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (level_o == '0));

  for (genvar j = 0; j < 2 * N_CELLS; j++) begin : g_leg
    a_r4_leg_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(gate_o[2*j] && gate_o[2*j+1]));

    a_r5_hi_to_lo_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (dead_i > DT_W'(1) && $fell(gate_o[2*j])) |=> !gate_o[2*j+1]);

    a_r5_lo_to_hi_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (dead_i > DT_W'(1) && $fell(gate_o[2*j+1])) |=> !gate_o[2*j]);
  end

endmodule

bind mlpwm_top mlpwm_chk #(
  .N_CELLS (N_CELLS),
  .DT_W    (DT_W),
  .LVL_W   (LVL_W)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .en_i    (en_i),
  .dead_i  (dead_i),
  .gate_o  (gate_o),
  .level_o (level_o)
);

// File: tb/mlpwm_top_tb_top.sv
module mlpwm_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int N_CELLS    = 2;
  localparam int MOD_W      = 12;
  localparam int CNT_W      = 10;
  localparam int DT_W       = 4;
  localparam int LVL_W      = 3;
  localparam int NG         = 4 * N_CELLS;
  localparam int NL         = 2 * N_CELLS;
  localparam int PER        = 8;
  localparam int DEAD       = 2;

  // stimulus / expected: modulating value, min and max level over a period (P = 8)
  localparam int VEC_N = 9;
  localparam int V_MOD [VEC_N] = '{ 20, -20,  0, 12, -12, 4, 16, -16, 8};
  localparam int V_MIN [VEC_N] = '{  2,  -2, -1,  1,  -2, 0,  1,  -2, 0};
  localparam int V_MAX [VEC_N] = '{  2,  -2,  0,  2,  -1, 1,  2,  -2, 1};

  logic                    clk_i = 1'b0;
  logic                    rst_ni;
  logic                    en_i;
  logic                    tick_i = 1'b0;
  logic signed [MOD_W-1:0] mod_i;
  logic [CNT_W-1:0]        period_i;
  logic [DT_W-1:0]         dead_i;
  logic [NG-1:0]           gate_o;
  logic signed [LVL_W-1:0] level_o;

  int checks = 0;
  int errors = 0;
  int r5_seen = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;
  always @(negedge clk_i) tick_i <= ~tick_i;

  mlpwm_top dut_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .tick_i   (tick_i),
    .mod_i    (mod_i),
    .period_i (period_i),
    .dead_i   (dead_i),
    .gate_o   (gate_o),
    .level_o  (level_o)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  function automatic logic [NG-1:0] exp_gates(int lvl);
    logic [NG-1:0] g;
    logic [3:0]    q;
    g = '0;
    for (int c = 0; c < N_CELLS; c++) begin
      if (lvl > c)       q = 4'b1001;
      else if (lvl < -c) q = 4'b0110;
      else               q = 4'b0101;
      g[4*c +: 4] = q;
    end
    return g;
  endfunction

  // per-cycle monitors, sampled after the rising edge
  int stable = 0;
  int prev_lvl = 0;
  int off_run [NL];
  int last_side [NL];

  always begin
    @(posedge clk_i);
    #(CLK_PERIOD*3/10);
    for (int j = 0; j < NL; j++) begin
      if (gate_o[2*j] && gate_o[2*j+1])
        chk(1'b0, "R4", {gate_o[2*j+1], gate_o[2*j]}, 0);
    end
    if (!rst_ni || !en_i) begin
      stable   = 0;
      prev_lvl = int'(level_o);
      for (int j = 0; j < NL; j++) begin
        off_run[j]   = 0;
        last_side[j] = -1;
      end
    end else begin
      if (int'(level_o) == prev_lvl) stable++;
      else stable = 0;
      prev_lvl = int'(level_o);
      if (stable >= DEAD + 3)
        chk(gate_o == exp_gates(int'(level_o)), "R3", gate_o, exp_gates(int'(level_o)));
      for (int j = 0; j < NL; j++) begin
        if (!gate_o[2*j] && !gate_o[2*j+1]) begin
          off_run[j]++;
        end else begin
          if ((gate_o[2*j] && last_side[j] == 0) || (gate_o[2*j+1] && last_side[j] == 1)) begin
            r5_seen++;
            chk(off_run[j] >= DEAD, "R5", off_run[j], DEAD);
          end
          last_side[j] = gate_o[2*j] ? 1 : 0;
          off_run[j]   = 0;
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    chk(1'b0, "watchdog", 0, 1);
    report();
    $finish;
  end

  initial begin
    int mn, mx;
    rst_ni   = 1'b0;
    en_i     = 1'b0;
    mod_i    = '0;
    period_i = CNT_W'(PER);
    dead_i   = DT_W'(DEAD);
    repeat (3) @(negedge clk_i);
    chk(gate_o == '0, "R7", gate_o, 0);
    chk(level_o == '0, "R7", level_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(gate_o == '0, "R6", gate_o, 0);

    // R2: sample only at the trough
    en_i  = 1'b1;
    mod_i = MOD_W'(-20);
    repeat (4) @(negedge clk_i);
    mod_i = MOD_W'(20);
    repeat (16) @(negedge clk_i);
    chk(int'(level_o) == -2, "R2", level_o, -2);
    repeat (44) @(negedge clk_i);
    chk(int'(level_o) == 2, "R2", level_o, 2);
    chk(gate_o == 8'h99, "R3", gate_o, 8'h99);

    // R1 table walk
    for (int i = 0; i < VEC_N; i++) begin
      mod_i = MOD_W'(V_MOD[i]);
      repeat (80) @(negedge clk_i);
      mn = 99;
      mx = -99;
      repeat (64) begin
        @(negedge clk_i);
        if (int'(level_o) < mn) mn = int'(level_o);
        if (int'(level_o) > mx) mx = int'(level_o);
      end
      chk(mn == V_MIN[i], "R1", mn, V_MIN[i]);
      chk(mx == V_MAX[i], "R1", mx, V_MAX[i]);
    end

    // R6: disable and restart
    mod_i = MOD_W'(20);
    repeat (80) @(negedge clk_i);
    chk(gate_o == 8'h99, "R3", gate_o, 8'h99);
    en_i = 1'b0;
    @(negedge clk_i);
    chk(gate_o == '0, "R6", gate_o, 0);
    chk(level_o == '0, "R6", level_o, 0);
    mod_i = MOD_W'(-20);
    repeat (3) @(negedge clk_i);
    en_i = 1'b1;
    repeat (12) @(negedge clk_i);
    chk(int'(level_o) == -2, "R6", level_o, -2);
    chk(gate_o == 8'h66, "R3", gate_o, 8'h66);

    // R8: period 0 clamps to 1
    period_i = '0;
    mod_i    = MOD_W'(1);
    repeat (40) @(negedge clk_i);
    mn = 99;
    mx = -99;
    repeat (32) begin
      @(negedge clk_i);
      if (int'(level_o) < mn) mn = int'(level_o);
      if (int'(level_o) > mx) mx = int'(level_o);
    end
    chk(mn == 0, "R8", mn, 0);
    chk(mx == 1, "R8", mx, 1);
    period_i = CNT_W'(PER);

    chk(r5_seen > 0, "R5", r5_seen, 1);

    // R7: reset mid-run
    rst_ni = 1'b0;
    @(negedge clk_i);
    chk(gate_o == '0, "R7", gate_o, 0);
    chk(level_o == '0, "R7", level_o, 0);

    report();
    $finish;
  end

endmodule